// File: doc/BRIEF.md
# Reduced Boundary-Scan Test Port Controller

This block is the serial test port of a memory device. A tester moves a 16-state controller with a mode line sampled on rising clock edges, loads a 3-bit instruction, and then moves data through one of three data registers: a 1-bit bypass cell, a 32-bit identification word, or a boundary register that samples the device's I/O ring. The data-register instructions are only partly implemented. The pin-driving and preload instructions fall back to capturing the I/O ring, and the scan chain never drives a device pin or a buffer.

The serial output changes on falling clock edges and sends the least significant bit first. It comes with an enable that is high only while the controller is in one of the two shift states, so the pad can float otherwise. The port has no stream interface: the serial lines are plain pins and no back-pressure exists. An asynchronous active-low reset is provided. A run of mode-line ones also resets the controller, and neither reset disturbs memory traffic.

Top module: `scan_port_ctrl`

## Requirements
- R1: An active-low `trst_n` puts the controller in Test-Logic-Reset, clears `tdo_oe` at once and selects IDCODE (code 001). A following data scan then returns the 32-bit `ID_CODE`, least significant bit first, and bit 0 of that word is 1.
- R2: Five consecutive rising `tck` edges with `tms` high bring the controller to Test-Logic-Reset from any state, and the instruction returns to IDCODE.
- R3: Each instruction scan first returns the fixed pattern 001: the first bit out is 1, the next two are 0.
- R4: Instruction bits enter on `tdi`, least significant bit first, and take effect when the controller passes Update-IR. Code 111 selects a 1-bit bypass cell that captures 0, so data passes with one bit of delay.
- R5: The spare codes 011, 101 and 110 behave as bypass, which keeps the chain continuous.
- R6: Codes 000, 100 and 010 select the `RING_W`-bit boundary register. On Capture-DR it samples `ring_in`. It shifts out LSB first while `tdi` enters at the MSB, and `ring_in` changes made after the capture do not alter the shifted word.
- R7: Data shifted into the boundary register reaches no output other than `tdo`. The next Capture-DR loads the live `ring_in` again, not the shifted-in value.
- R8: `tdo_oe` is high only while the controller is in Shift-IR or Shift-DR. It follows the state on the falling edge of `tck`.
- R9: `tdo` changes only on falling edges of `tck`, and its value is held across each rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous active-low controller reset |
| tms | input | 1 | Mode select, sampled on rising `tck` |
| tdi | input | 1 | Serial data in, sampled on rising `tck` |
| ring_in | input | RING_W | Live values of the device I/O ring |
| tdo | output | 1 | Serial data out, updated on falling `tck` |
| tdo_oe | output | 1 | Output enable for the `tdo` pad driver |

## Verification
Two functions can share a rising edge. The last shift of a scan uses the same edge as the mode-line one that leaves the shift state. The first edge of a five-ones reset run can also still be a shift edge. The bench sets `tms` high on the final bit of every scan and starts reset runs from inside Shift-DR and Pause-IR. It then checks that the word is complete and correctly delayed, that `tdo_oe` drops, and that the next data scan returns the identification word.

// File: rtl/scan_pkg.sv
package scan_pkg;

  typedef enum logic [3:0] {
    ST_RESET   = 4'h0,
    ST_IDLE    = 4'h1,
    ST_SEL_DR  = 4'h2,
    ST_CAP_DR  = 4'h3,
    ST_SH_DR   = 4'h4,
    ST_EX1_DR  = 4'h5,
    ST_PAU_DR  = 4'h6,
    ST_EX2_DR  = 4'h7,
    ST_UPD_DR  = 4'h8,
    ST_SEL_IR  = 4'h9,
    ST_CAP_IR  = 4'hA,
    ST_SH_IR   = 4'hB,
    ST_EX1_IR  = 4'hC,
    ST_PAU_IR  = 4'hD,
    ST_EX2_IR  = 4'hE,
    ST_UPD_IR  = 4'hF
  } tap_state_e;

  localparam int unsigned IR_W = 3;

  localparam logic [IR_W-1:0] OP_RING_DRIVE = 3'b000;
  localparam logic [IR_W-1:0] OP_IDENT      = 3'b001;
  localparam logic [IR_W-1:0] OP_RING_FLOAT = 3'b010;
  localparam logic [IR_W-1:0] OP_RING_SAMP  = 3'b100;
  localparam logic [IR_W-1:0] OP_PASS       = 3'b111;
  localparam logic [IR_W-1:0] IR_CAPTURE    = 3'b001;

  typedef enum logic [1:0] {
    SEL_PASS = 2'd0,
    SEL_IDENT = 2'd1,
    SEL_RING = 2'd2
  } dr_sel_e;

  function automatic dr_sel_e decode_dr(input logic [IR_W-1:0] op);
    case (op)
      OP_IDENT:                                  return SEL_IDENT;
      OP_RING_DRIVE, OP_RING_FLOAT, OP_RING_SAMP: return SEL_RING;
      default:                                   return SEL_PASS;
    endcase
  endfunction

endpackage

// File: rtl/scan_fsm.sv
module scan_fsm
  import scan_pkg::*;
(
  input  logic       tck,
  input  logic       trst_n,
  input  logic       tms,
  output tap_state_e state
);

  tap_state_e nxt;

  always_comb begin
    nxt = state;
    case (state)
      ST_RESET:  nxt = tms ? ST_RESET  : ST_IDLE;
      ST_IDLE:   nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
      ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_SH_DR:  nxt = tms ? ST_EX1_DR : ST_SH_DR;
      ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
      ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
      ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SH_DR;
      ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      ST_SEL_IR: nxt = tms ? ST_RESET  : ST_CAP_IR;
      ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_SH_IR:  nxt = tms ? ST_EX1_IR : ST_SH_IR;
      ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
      ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
      ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SH_IR;
      ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_IDLE;
      default:   nxt = ST_RESET;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) state <= ST_RESET;
    else         state <= nxt;
  end

endmodule

// File: rtl/scan_ir.sv
module scan_ir
  import scan_pkg::*;
(
  input  logic            tck,
  input  logic            trst_n,
  input  tap_state_e      state,
  input  logic            tdi,
  output logic [IR_W-1:0] ir_cur,
  output logic [IR_W-1:0] ir_shift
);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir_shift <= IR_CAPTURE;
      ir_cur   <= OP_IDENT;
    end else begin
      case (state)
        ST_RESET:  ir_cur   <= OP_IDENT;
        ST_CAP_IR: ir_shift <= IR_CAPTURE;
        ST_SH_IR:  ir_shift <= {tdi, ir_shift[IR_W-1:1]};
        ST_UPD_IR: ir_cur   <= ir_shift;
        default:   ;
      endcase
    end
  end

endmodule

// File: rtl/scan_dr_bank.sv
module scan_dr_bank
  import scan_pkg::*;
#(
  parameter int unsigned RING_W  = 12,
  parameter int unsigned ID_W    = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h1A5B_9003
)(
  input  logic              tck,
  input  logic              trst_n,
  input  tap_state_e        state,
  input  logic [IR_W-1:0]   ir_cur,
  input  logic              tdi,
  input  logic [RING_W-1:0] ring_in,
  output logic              dr_lsb
);

  dr_sel_e           sel;
  logic              pass_q;
  logic [ID_W-1:0]   id_q;
  logic [RING_W-1:0] ring_q;

  assign sel = decode_dr(ir_cur);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      pass_q <= 1'b0;
      id_q   <= ID_CODE;
      ring_q <= '0;
    end else if (state == ST_CAP_DR) begin
      case (sel)
        SEL_IDENT: id_q   <= ID_CODE;
        SEL_RING:  ring_q <= ring_in;
        default:   pass_q <= 1'b0;
      endcase
    end else if (state == ST_SH_DR) begin
      case (sel)
        SEL_IDENT: id_q   <= {tdi, id_q[ID_W-1:1]};
        SEL_RING:  ring_q <= {tdi, ring_q[RING_W-1:1]};
        default:   pass_q <= tdi;
      endcase
    end
  end

  always_comb begin
    case (sel)
      SEL_IDENT: dr_lsb = id_q[0];
      SEL_RING:  dr_lsb = ring_q[0];
      default:   dr_lsb = pass_q;
    endcase
  end

endmodule

// File: rtl/scan_port_ctrl.sv
module scan_port_ctrl
  import scan_pkg::*;
#(
  parameter int unsigned RING_W  = 12,
  parameter int unsigned ID_W    = 32,
  parameter logic [ID_W-1:0] ID_CODE = 32'h1A5B_9003
)(
  input  logic              tck,
  input  logic              trst_n,
  input  logic              tms,
  input  logic              tdi,
  input  logic [RING_W-1:0] ring_in,
  output logic              tdo,
  output logic              tdo_oe
);

  tap_state_e      fsm_state;
  logic [IR_W-1:0] ir_cur;
  logic [IR_W-1:0] ir_shift;
  logic            dr_lsb;

  scan_fsm u_fsm (
    .tck(tck), .trst_n(trst_n), .tms(tms), .state(fsm_state)
  );

  scan_ir u_ir (
    .tck(tck), .trst_n(trst_n), .state(fsm_state), .tdi(tdi),
    .ir_cur(ir_cur), .ir_shift(ir_shift)
  );

  scan_dr_bank #(.RING_W(RING_W), .ID_W(ID_W), .ID_CODE(ID_CODE)) u_dr (
    .tck(tck), .trst_n(trst_n), .state(fsm_state), .ir_cur(ir_cur),
    .tdi(tdi), .ring_in(ring_in), .dr_lsb(dr_lsb)
  );

  // Output stage: falling-edge retiming of the selected LSB and pad enable.
  always_ff @(negedge tck or negedge trst_n) begin
    if (!trst_n) begin
      tdo    <= 1'b0;
      tdo_oe <= 1'b0;
    end else begin
      tdo_oe <= (fsm_state == ST_SH_IR) || (fsm_state == ST_SH_DR);
      if (fsm_state == ST_SH_IR)      tdo <= ir_shift[0];
      else if (fsm_state == ST_SH_DR) tdo <= dr_lsb;
    end
  end

endmodule

// File: rtl/scan_port_ctrl_chk.sv
module scan_port_ctrl_chk
  import scan_pkg::*;
(
  input logic            tck,
  input logic            trst_n,
  input logic            tms,
  input tap_state_e      state,
  input logic [IR_W-1:0] ir_cur,
  input logic [IR_W-1:0] ir_shift,
  input logic            tdo_oe
);

  logic [2:0] ones;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)           ones <= 3'd0;
    else if (!tms)         ones <= 3'd0;
    else if (ones != 3'd5) ones <= ones + 3'd1;
  end

  assert_reset_loads_ident_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_RESET) |=> (ir_cur == OP_IDENT));

  assert_five_ones_reset_R2: assert property (@(posedge tck) disable iff (!trst_n)
    (ones == 3'd5) |-> (state == ST_RESET));

  assert_capture_pattern_R3: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_CAP_IR) |=> (ir_shift == IR_CAPTURE));

  assert_update_takes_shift_R4: assert property (@(posedge tck) disable iff (!trst_n)
    (state == ST_UPD_IR) |=> (ir_cur == $past(ir_shift)));

  assert_oe_in_shift_only_R8: assert property (@(posedge tck) disable iff (!trst_n)
    tdo_oe == ((state == ST_SH_IR) || (state == ST_SH_DR)));

endmodule

bind scan_port_ctrl scan_port_ctrl_chk u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .state(fsm_state),
  .ir_cur(ir_cur), .ir_shift(ir_shift), .tdo_oe(tdo_oe)
);

// File: tb/scan_port_ctrl_test.sv
module scan_port_ctrl_test;

  localparam int unsigned RW = 12;
  localparam logic [31:0] ID_EXP = 32'h1A5B_9003;

  logic          tck = 1'b0;
  logic          trst_n = 1'b0;
  logic          tms = 1'b1;
  logic          tdi = 1'b0;
  logic [RW-1:0] ring_in = '0;
  logic          tdo;
  logic          tdo_oe;

  int vectors = 0;
  int misses  = 0;
  int cycles  = 0;

  scan_port_ctrl #(.RING_W(RW), .ID_W(32), .ID_CODE(ID_EXP)) uut (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi),
    .ring_in(ring_in), .tdo(tdo), .tdo_oe(tdo_oe)
  );

  always #5 tck = ~tck;

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  always @(posedge tck) begin
    cycles++;
    if (cycles > 100000) begin
      misses++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  // One tck period; checks the R9 hold across the rising edge while shifting.
  task automatic step(input logic m, input logic d);
    logic was_on, was_tdo;
    was_on = tdo_oe;
    was_tdo = tdo;
    tms = m;
    tdi = d;
    @(posedge tck); #1;
    if (was_on) check("R9 tdo held over rising edge", 64'(tdo), 64'(was_tdo));
    @(negedge tck); #1;
  endtask

  task automatic load_ir(input logic [2:0] code, output logic [2:0] cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0);
    check("R8 oe in Shift-IR", 64'(tdo_oe), 64'd1);
    for (int i = 0; i < 3; i++) begin
      cap[i] = tdo;
      step(i == 2, code[i]);
    end
    check("R8 oe in Exit1-IR", 64'(tdo_oe), 64'd0);
    step(1, 0); step(0, 0);
  endtask

  task automatic shift_dr(input int n, input logic [63:0] din,
                          input logic [RW-1:0] ring_after, output logic [63:0] dout);
    dout = '0;
    step(1, 0); step(0, 0);
    check("R8 oe in Capture-DR", 64'(tdo_oe), 64'd0);
    step(0, 0);
    ring_in = ring_after;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo;
      step(i == n - 1, din[i]);
    end
    step(1, 0); step(0, 0);
    check("R8 oe back in Idle", 64'(tdo_oe), 64'd0);
  endtask

  task automatic t_reset;
    logic [63:0] d;
    check("R1 oe during reset", 64'(tdo_oe), 64'd0);
    #7 trst_n = 1'b1;
    @(negedge tck); #1;
    step(0, 0);
    shift_dr(32, 64'h0, '0, d);
    check("R1 ident word after reset", d[31:0], 64'(ID_EXP));
    check("R1 ident bit0 is 1", 64'(d[0]), 64'd1);
  endtask

  task automatic t_capture_ir;
    logic [2:0] cap;
    load_ir(3'b001, cap);
    check("R3 capture pattern 001", 64'(cap), 64'd1);
  endtask

  task automatic t_bypass(input logic [2:0] code, input string tag);
    logic [2:0] cap;
    logic [63:0] d;
    logic [7:0] p;
    p = 8'hB5 ^ {5'd0, code};
    load_ir(code, cap);
    shift_dr(8, 64'(p), '0, d);
    check(tag, d[7:0], 64'({p[6:0], 1'b0}));
  endtask

  task automatic t_ring(input logic [2:0] code);
    logic [2:0] cap;
    logic [63:0] d;
    logic [RW-1:0] v1, v2, pin;
    v1 = 12'hA3C ^ {9'd0, code};
    v2 = 12'h5E1;
    pin = 12'h7D2;
    load_ir(code, cap);
    ring_in = v1;
    shift_dr(2 * RW, {40'd0, pin, 12'h000}, 12'hFFF, d);
    check("R6 ring captured, later change ignored", d[RW-1:0], 64'(v1));
    check("R6 tdi reaches ring MSB side", d[2*RW-1:RW], 64'd0);
    shift_dr(RW, 64'(pin), v2, d);
    ring_in = v2;
    shift_dr(RW, 64'h0, v2, d);
    check("R7 recapture takes live ring, no preload", d[RW-1:0], 64'(v2));
    ring_in = v1;
    shift_dr(2 * RW, {40'd0, pin, 12'h000}, v1, d);
    check("R6 chain continuity after RING_W bits", d[2*RW-1:RW], 64'd0);
    shift_dr(2 * RW, {40'd0, 12'h000, pin}, v1, d);
    check("R6 shifted-in word emerges after RING_W", d[2*RW-1:RW], 64'(pin));
  endtask

  task automatic t_tms_reset_from_shift;
    logic [2:0] cap;
    logic [63:0] d;
    load_ir(3'b111, cap);
    step(1, 0); step(0, 0); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 1);
    check("R2 oe low after five ones", 64'(tdo_oe), 64'd0);
    step(0, 0);
    shift_dr(32, 64'h0, '0, d);
    check("R2 ident after reset from Shift-DR", d[31:0], 64'(ID_EXP));
  endtask

  task automatic t_tms_reset_from_pause_ir;
    logic [2:0] cap;
    logic [63:0] d;
    load_ir(3'b100, cap);
    step(1, 0); step(1, 0); step(0, 0); step(0, 0); step(1, 1); step(0, 0);
    for (int i = 0; i < 5; i++) step(1, 0);
    step(0, 0);
    shift_dr(32, 64'h0, '0, d);
    check("R2 ident after reset from Pause-IR", d[31:0], 64'(ID_EXP));
  endtask

  task automatic t_async_reset;
    logic [2:0] cap;
    logic [63:0] d;
    load_ir(3'b111, cap);
    step(1, 0); step(0, 0); step(0, 0);
    check("R8 oe in Shift-DR", 64'(tdo_oe), 64'd1);
    #1 trst_n = 1'b0;
    #1 check("R1 oe drops with trst_n", 64'(tdo_oe), 64'd0);
    #1 trst_n = 1'b1;
    @(negedge tck); #1;
    step(0, 0);
    shift_dr(32, 64'h0, '0, d);
    check("R1 ident after async reset", d[31:0], 64'(ID_EXP));
  endtask

  initial begin
    t_reset();
    t_capture_ir();
    t_bypass(3'b111, "R4 bypass one-bit delay");
    t_bypass(3'b011, "R5 spare 011 as bypass");
    t_bypass(3'b101, "R5 spare 101 as bypass");
    t_bypass(3'b110, "R5 spare 110 as bypass");
    t_ring(3'b000);
    t_ring(3'b010);
    t_ring(3'b100);
    t_tms_reset_from_shift();
    t_tms_reset_from_pause_ir();
    t_async_reset();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule